// File: doc/BRIEF.md
# DMA Global Control and Interrupt Aggregator

This block is the shared register file that sits beside the channel engines of a multi-channel DMA controller. Software reaches it through a 32-bit register bus addressed by word index. In it are a master enable, two sticky summary flags (one for address errors, one for halts), a per-channel clock-enable vector, a per-channel doorbell, and a per-channel pending vector. The pending vector is folded into a single interrupt line.

Channel engines report done, halt and address-error events as single-cycle strobes, one bit per channel. Any of these events marks the channel pending. A halt or an address error also sets the matching summary flag. The interrupt handler reads the pending vector, services some channels, and writes the vector back with the serviced bits at zero. Channels that were not serviced, or that raise a new event in that same cycle, stay pending. The clock-enable vector can be written whole, or changed bit by bit through set and clear aliases. Writing the doorbell set alias sends a one-cycle start pulse to each selected channel.

Top module: `dma_glob_ctrl`

## Requirements
- R1: After reset is asserted (active low, asynchronous), every register reads 0, and `irq`, `clkEnable` and `doorbell` are all 0.
- R2: Word index 0 is the control register. Bit 0 is the enable and is read/write. Bit 2 is the address-error summary, bit 3 is the halt summary, and all other bits read 0.
- R3: Any channel's address-error event sets control bit 2, and any channel's halt event sets control bit 3. A control write with 0 in one of these bits clears it, and a 1 leaves it unchanged. An event in the same cycle as a clearing write wins, so the flag stays set.
- R4: A done, halt or address-error event on channel n sets bit n of the pending register at word index 1 on the next clock edge.
- R5: A write to the pending register clears each bit written as 0 and leaves each bit written as 1 unchanged. A write never sets a pending bit.
- R6: If a channel event coincides with a pending write that clears the same bit, the bit stays set.
- R7: `irq` is high exactly when the enable bit is set and at least one pending bit is set.
- R8: A write to word index 4 loads the clock-enable vector, which reads back at index 4 and drives `clkEnable`.
- R9: A 1 in bit n of a write to index 5 sets clock-enable bit n, and a 1 in bit n of a write to index 6 clears it. Zero bits change nothing. Indexes 5 and 6 read 0.
- R10: A write to index 3 with bit n set drives `doorbell[n]` high for exactly the one cycle after the write edge. Index 2 reads 0, and writes to index 2 have no effect.
- R11: Index 7 is unmapped. It reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Word index of the accessed register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `regAddr` (combinational) |
| evtDone | input | NumChan | Per-channel transfer-done event |
| evtHalt | input | NumChan | Per-channel halt event |
| evtAddrErr | input | NumChan | Per-channel address-error event |
| clkEnable | output | NumChan | Per-channel clock enable |
| doorbell | output | NumChan | Per-channel one-cycle descriptor-fetch pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach are the races between software and hardware: a write-back that clears a pending bit, or a write that clears a summary flag, landing in the same clock edge as a new event on that channel. The stimulus table drives the event strobe and the bus write in the same vector, so both are sampled at one edge. The next read must then show the bit still set. The doorbell pulse leaves no readable trace, so it is sampled right after the write edge and again one cycle later.

// File: rtl/dma_glob_pkg.sv
package dma_glob_pkg;

  localparam int DataW    = 32;
  localparam int IdxW     = 3;
  localparam int EnBit    = 0;
  localparam int AErrBit  = 2;
  localparam int HaltBit  = 3;

  typedef enum logic [IdxW-1:0] {
    IDX_CTRL    = 3'd0,
    IDX_PEND    = 3'd1,
    IDX_BELL    = 3'd2,
    IDX_BELLSET = 3'd3,
    IDX_CLK     = 3'd4,
    IDX_CLKSET  = 3'd5,
    IDX_CLKCLR  = 3'd6,
    IDX_NONE    = 3'd7
  } regIdx_t;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrPend;
    logic    setBell;
    logic    wrClk;
    logic    setClk;
    logic    clrClk;
    regIdx_t rdSel;
  } regStrobe_t;

endpackage

// File: rtl/dma_glob_decode.sv
module dma_glob_decode
  import dma_glob_pkg::*;
(
  input  logic            wrEn,
  input  logic [IdxW-1:0] regAddr,
  output regStrobe_t      strobe
);

  regIdx_t idx;
  assign idx = regIdx_t'(regAddr);

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = idx;
    if (wrEn) begin
      unique case (idx)
        IDX_CTRL:    strobe.wrCtrl  = 1'b1;
        IDX_PEND:    strobe.wrPend  = 1'b1;
        IDX_BELLSET: strobe.setBell = 1'b1;
        IDX_CLK:     strobe.wrClk   = 1'b1;
        IDX_CLKSET:  strobe.setClk  = 1'b1;
        IDX_CLKCLR:  strobe.clrClk  = 1'b1;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/dma_glob_regs.sv
module dma_glob_regs
  import dma_glob_pkg::*;
#(
  parameter int NumChan = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  logic [DataW-1:0]   wrData,
  input  logic [NumChan-1:0] evtDone,
  input  logic [NumChan-1:0] evtHalt,
  input  logic [NumChan-1:0] evtAddrErr,
  output logic [DataW-1:0]   rdData,
  output logic [NumChan-1:0] clkEnable,
  output logic [NumChan-1:0] doorbell,
  output logic               irq
);

  logic               ctrlEn;
  logic               aErrSum;
  logic               haltSum;
  logic [NumChan-1:0] pend;
  logic [NumChan-1:0] clkEnQ;
  logic [NumChan-1:0] bellQ;
  logic [NumChan-1:0] evtAny;
  logic               unusedWrBits;

  assign evtAny       = evtDone | evtHalt | evtAddrErr;
  assign unusedWrBits = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn  <= 1'b0;
      aErrSum <= 1'b0;
      haltSum <= 1'b0;
    end else begin
      if (strobe.wrCtrl) ctrlEn <= wrData[EnBit];
      if (|evtAddrErr) aErrSum <= 1'b1;
      else if (strobe.wrCtrl && !wrData[AErrBit]) aErrSum <= 1'b0;
      if (|evtHalt) haltSum <= 1'b1;
      else if (strobe.wrCtrl && !wrData[HaltBit]) haltSum <= 1'b0;
    end
  end

  for (genvar c = 0; c < NumChan; c++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pend[c]   <= 1'b0;
        clkEnQ[c] <= 1'b0;
        bellQ[c]  <= 1'b0;
      end else begin
        if (evtAny[c]) pend[c] <= 1'b1;
        else if (strobe.wrPend && !wrData[c]) pend[c] <= 1'b0;

        if (strobe.wrClk) clkEnQ[c] <= wrData[c];
        else if (strobe.setClk && wrData[c]) clkEnQ[c] <= 1'b1;
        else if (strobe.clrClk && wrData[c]) clkEnQ[c] <= 1'b0;

        bellQ[c] <= strobe.setBell & wrData[c];
      end
    end
  end

  logic [DataW-1:0] pendW;
  logic [DataW-1:0] clkW;
  logic [DataW-1:0] ctrlW;

  always_comb begin
    pendW = '0;
    pendW[NumChan-1:0] = pend;
    clkW = '0;
    clkW[NumChan-1:0] = clkEnQ;
    ctrlW = '0;
    ctrlW[EnBit]   = ctrlEn;
    ctrlW[AErrBit] = aErrSum;
    ctrlW[HaltBit] = haltSum;
  end

  always_comb begin
    unique case (strobe.rdSel)
      IDX_CTRL: rdData = ctrlW;
      IDX_PEND: rdData = pendW;
      IDX_CLK:  rdData = clkW;
      default:  rdData = '0;
    endcase
  end

  assign clkEnable = clkEnQ;
  assign doorbell  = bellQ;
  assign irq       = ctrlEn & (|pend);

  // R4: an event always leaves its pending bit set
  a_r4_event_sets_pend: assert property (@(posedge clk) disable iff (!rstN)
    (|evtAny) |=> ((pend & $past(evtAny)) == $past(evtAny)));

  // R5: without an event, no pending bit can rise
  a_r5_no_spurious_pend: assert property (@(posedge clk) disable iff (!rstN)
    !(|evtAny) |=> ((pend & ~$past(pend)) == '0));

  // R3: a halt event always sets the halt summary
  a_r3_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (|evtHalt) |=> haltSum);

  // R7: an event while enabled and not re-writing control raises irq
  a_r7_event_irq: assert property (@(posedge clk) disable iff (!rstN)
    ((|evtAny) && ctrlEn && !strobe.wrCtrl) |=> irq);

  // R9: bits named in a clear-alias write are off afterwards
  a_r9_clear_alias: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrClk |=> ((clkEnable & $past(wrData[NumChan-1:0])) == '0));

  // R10: doorbell only pulses after a set-alias write
  a_r10_bell_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.setBell |=> (doorbell == '0));

endmodule

// File: rtl/dma_glob_ctrl.sv
module dma_glob_ctrl
  import dma_glob_pkg::*;
#(
  parameter int NumChan = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [NumChan-1:0] evtDone,
  input  logic [NumChan-1:0] evtHalt,
  input  logic [NumChan-1:0] evtAddrErr,
  output logic [NumChan-1:0] clkEnable,
  output logic [NumChan-1:0] doorbell,
  output logic               irq
);

  if (NumChan < 1 || NumChan > DataW) begin : g_bad_count
    initial $error("NumChan must lie in 1..32");
  end

  regStrobe_t strobe;

  dma_glob_decode uDecode (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  dma_glob_regs #(.NumChan(NumChan)) uRegs (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .evtDone    (evtDone),
    .evtHalt    (evtHalt),
    .evtAddrErr (evtAddrErr),
    .rdData     (rdData),
    .clkEnable  (clkEnable),
    .doorbell   (doorbell),
    .irq        (irq)
  );

endmodule

// File: tb/dma_glob_ctrl_test.sv
module dma_glob_ctrl_test;

  localparam int N = 8;

  typedef struct packed {
    logic        wr;
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [7:0]  dn;
    logic [7:0]  hl;
    logic [7:0]  ae;
    logic [2:0]  ra;
    logic [31:0] er;
    logic        ei;
    logic [7:0]  eb;
    logic [3:0]  req;
  } vec_t;

  localparam int NumVec = 23;

  localparam vec_t Vecs [NumVec] = '{
    '{1'b0, 3'd0, 32'h0,       8'h00, 8'h00, 8'h00, 3'd0, 32'h00, 1'b0, 8'h00, 4'd1},  // R1
    '{1'b0, 3'd0, 32'h0,       8'h00, 8'h00, 8'h00, 3'd1, 32'h00, 1'b0, 8'h00, 4'd1},  // R1
    '{1'b1, 3'd0, 32'h1,       8'h00, 8'h00, 8'h00, 3'd0, 32'h01, 1'b0, 8'h00, 4'd2},  // R2
    '{1'b0, 3'd0, 32'h0,       8'h04, 8'h00, 8'h00, 3'd1, 32'h04, 1'b1, 8'h00, 4'd4},  // R4 R7
    '{1'b0, 3'd0, 32'h0,       8'h00, 8'h20, 8'h00, 3'd0, 32'h09, 1'b1, 8'h00, 4'd3},  // R3
    '{1'b0, 3'd0, 32'h0,       8'h00, 8'h00, 8'h01, 3'd1, 32'h25, 1'b1, 8'h00, 4'd4},  // R4
    '{1'b1, 3'd1, 32'h21,      8'h00, 8'h00, 8'h00, 3'd1, 32'h21, 1'b1, 8'h00, 4'd5},  // R5
    '{1'b1, 3'd1, 32'hFF,      8'h00, 8'h00, 8'h00, 3'd1, 32'h21, 1'b1, 8'h00, 4'd5},  // R5
    '{1'b1, 3'd1, 32'h0,       8'h01, 8'h00, 8'h00, 3'd1, 32'h01, 1'b1, 8'h00, 4'd6},  // R6
    '{1'b1, 3'd0, 32'h0,       8'h00, 8'h00, 8'h00, 3'd0, 32'h00, 1'b0, 8'h00, 4'd7},  // R7 R3
    '{1'b1, 3'd0, 32'h0D,      8'h00, 8'h00, 8'h00, 3'd0, 32'h01, 1'b1, 8'h00, 4'd3},  // R3
    '{1'b1, 3'd0, 32'h1,       8'h00, 8'h02, 8'h00, 3'd0, 32'h09, 1'b1, 8'h00, 4'd3},  // R3
    '{1'b1, 3'd1, 32'h0,       8'h00, 8'h00, 8'h00, 3'd1, 32'h00, 1'b0, 8'h00, 4'd7},  // R7
    '{1'b1, 3'd4, 32'hA5,      8'h00, 8'h00, 8'h00, 3'd4, 32'hA5, 1'b0, 8'h00, 4'd8},  // R8
    '{1'b1, 3'd5, 32'h0A,      8'h00, 8'h00, 8'h00, 3'd4, 32'hAF, 1'b0, 8'h00, 4'd9},  // R9
    '{1'b1, 3'd6, 32'h81,      8'h00, 8'h00, 8'h00, 3'd4, 32'h2E, 1'b0, 8'h00, 4'd9},  // R9
    '{1'b1, 3'd6, 32'h0,       8'h00, 8'h00, 8'h00, 3'd5, 32'h00, 1'b0, 8'h00, 4'd9},  // R9
    '{1'b0, 3'd0, 32'h0,       8'h00, 8'h00, 8'h00, 3'd4, 32'h2E, 1'b0, 8'h00, 4'd9},  // R9
    '{1'b1, 3'd3, 32'h12,      8'h00, 8'h00, 8'h00, 3'd2, 32'h00, 1'b0, 8'h12, 4'd10}, // R10
    '{1'b0, 3'd0, 32'h0,       8'h00, 8'h00, 8'h00, 3'd2, 32'h00, 1'b0, 8'h00, 4'd10}, // R10
    '{1'b1, 3'd2, 32'hFF,      8'h00, 8'h00, 8'h00, 3'd2, 32'h00, 1'b0, 8'h00, 4'd10}, // R10
    '{1'b1, 3'd7, 32'hFFFFFFFF,8'h00, 8'h00, 8'h00, 3'd7, 32'h00, 1'b0, 8'h00, 4'd11}, // R11
    '{1'b0, 3'd0, 32'h0,       8'h00, 8'h00, 8'h00, 3'd0, 32'h09, 1'b0, 8'h00, 4'd11}  // R11
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [N-1:0]  evtDone = '0;
  logic [N-1:0]  evtHalt = '0;
  logic [N-1:0]  evtAddrErr = '0;
  logic [N-1:0]  clkEnable;
  logic [N-1:0]  doorbell;
  logic          irq;

  int numChecks = 0;
  int numFails  = 0;
  bit finished  = 1'b0;

  always #10 clk = ~clk;

  dma_glob_ctrl #(.NumChan(N)) uut (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .regAddr    (regAddr),
    .wrData     (wrData),
    .rdData     (rdData),
    .evtDone    (evtDone),
    .evtHalt    (evtHalt),
    .evtAddrErr (evtAddrErr),
    .clkEnable  (clkEnable),
    .doorbell   (doorbell),
    .irq        (irq)
  );

  task automatic check(input string what, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    numChecks++;
    if (act !== exp) begin
      numFails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic stepEvt(input logic [N-1:0] dn);
    @(negedge clk);
    evtDone = dn;
    @(posedge clk);
    #1;
    evtDone = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NumVec; i++) begin
      @(negedge clk);
      wrEn       = Vecs[i].wr;
      regAddr    = Vecs[i].wa;
      wrData     = Vecs[i].wd;
      evtDone    = Vecs[i].dn;
      evtHalt    = Vecs[i].hl;
      evtAddrErr = Vecs[i].ae;
      @(posedge clk);
      #1;
      wrEn = 1'b0; evtDone = '0; evtHalt = '0; evtAddrErr = '0;
      regAddr = Vecs[i].ra;
      #1;
      check($sformatf("vec %0d rdData", i), int'(Vecs[i].req), rdData, Vecs[i].er);
      check($sformatf("vec %0d irq", i), int'(Vecs[i].req), {31'b0, irq}, {31'b0, Vecs[i].ei});
      check($sformatf("vec %0d doorbell", i), int'(Vecs[i].req), {24'b0, doorbell},
            {24'b0, Vecs[i].eb});
    end

    // R4: highest channel index
    stepEvt(8'h80);
    regAddr = 3'd1;
    #1;
    check("top channel pending", 4, rdData, 32'h80);
    check("top channel irq R7", 7, {31'b0, irq}, 32'h1);

    // R10: all channels ring, pulse lasts one cycle only
    @(negedge clk);
    wrEn = 1'b1; regAddr = 3'd3; wrData = 32'hFF;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
    check("all doorbells high", 10, {24'b0, doorbell}, 32'hFF);
    @(posedge clk);
    #1;
    check("all doorbells dropped", 10, {24'b0, doorbell}, 32'h00);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rstN = 1'b0;
    #1;
    regAddr = 3'd4;
    #1;
    check("reset clock enable", 1, rdData, 32'h0);
    check("reset clkEnable port", 1, {24'b0, clkEnable}, 32'h0);
    regAddr = 3'd1;
    #1;
    check("reset pending", 1, rdData, 32'h0);
    regAddr = 3'd0;
    #1;
    check("reset control", 1, rdData, 32'h0);
    check("reset irq", 1, {31'b0, irq}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      numChecks++;
      numFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
      $finish;
    end
  end

endmodule